// File: doc/BRIEF.md
# Redirection Table Register Window

This block is the software-facing register file of an interrupt router. It owns one 64-bit redirection entry per interrupt input pin. Software reaches everything through two 32-bit locations on a simple valid/write/address/data port. First it stores an 8-bit index in a select register. Then it reads or writes the addressed 32-bit register through a data window. The index picks an identification register, a read-only version register, or one 32-bit half of a redirection entry.

The complete table is exported as a flat vector, so a separate delivery engine can decode it. That engine reports back through per-pin hooks: a set and a clear for each entry's remote-IRR bit, and a busy flag that shows up as the entry's delivery-status bit. Software writes never disturb these two bits. Whenever an entry is written with its trigger bit showing edge mode, its remote-IRR bit is cleared.

Top module: `redir_regwin`

## Requirements
- R1: After reset the select register and the ID field read 0, and every entry holds 0x0000_0000_0001_0000 (only bit 16, the mask bit, set).
- R2: The select register sits at bus offset 0x00. Only address bits 7:0 are decoded, so 0x100 also reaches it. A write stores wdata[7:0], and a read returns that value zero-extended.
- R3: Index 0x00 is the ID register. A window write keeps wdata[27:24], and a window read returns that field in bits 27:24 with every other bit zero.
- R4: Index 0x01 reads the constant {8'h00, NUM_PINS-1, 8'h00, 8'h11}. Window writes to it have no effect.
- R5: Index 0x10+2k reaches bits 31:0 of entry k and index 0x11+2k reaches bits 63:32, through the window at offset 0x10. Entry k appears at entries_o[64k+63:64k].
- R6: Indices 0x02–0x0F and indices at or above 0x10+2·NUM_PINS read as zero, and writes to them change no register.
- R7: Bit 12 (delivery status) and bit 14 (remote IRR) of an entry keep their previous values across software writes. All other bits take the written data.
- R8: After any write to either half of an entry, bit 14 is cleared if bit 15 (trigger: 0 edge, 1 level) of the result is 0.
- R9: With no software write to entry k in the same cycle, irr_set[k] sets bit 14 and irr_clr[k] clears it on the next edge. Set wins over clear. The hooks of other pins do not touch entry k.
- R10: When a software write to entry k and a hook for entry k fall in the same cycle, the hook is ignored and R7/R8 decide bit 14.
- R11: Bit 12 of entry k equals pend_i[k] as sampled on the previous clock edge.
- R12: Bus offsets other than 0x00 and 0x10 (low byte) read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 7:0 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address and state) |
| irr_set | input | NUM_PINS | Per-entry remote-IRR set hook |
| irr_clr | input | NUM_PINS | Per-entry remote-IRR clear hook |
| pend_i | input | NUM_PINS | Per-entry delivery-busy flag |
| entries_o | output | 64*NUM_PINS | All entries, entry k at bits 64k+63:64k |

## Verification
The bench builds the block with NUM_PINS = 4 and ADDR_W = 12. With four pins the last entry index is 0x17, so the first index past the table (0x18) and a version word with max-entry 3 are both cheap to reach. The 12-bit address makes it possible to show that bit 8 is ignored in decoding. Four pins also let one hook vector touch a neighbouring entry in the same cycle as a software write to another, which shows the hooks are isolated per pin.

// File: rtl/redir_pkg.sv
`timescale 1ns/1ps
package redir_pkg;
    localparam int WORD_W  = 32;
    localparam int ENT_W   = 64;
    localparam int IDX_W   = 8;
    // Entry bit positions decoded by the delivery engine
    localparam int B_DSTAT = 12;
    localparam int B_RIRR  = 14;
    localparam int B_TRIG  = 15;
    localparam int B_MASK  = 16;
    localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << B_MASK;
endpackage

// File: rtl/rw_entry.sv
`timescale 1ns/1ps
module rw_entry
    import redir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic              irr_set,
    input  logic              irr_clr,
    input  logic              pend,
    output logic [ENT_W-1:0]  entry_o
);
    logic [ENT_W-1:0] ent_d, ent_q;
    logic             sw_wr;

    always_comb begin
        sw_wr = wr_lo | wr_hi;
        ent_d = ent_q;
        if (wr_lo) ent_d[WORD_W-1:0]     = wdata;
        if (wr_hi) ent_d[ENT_W-1:WORD_W] = wdata;
        ent_d[B_RIRR] = ent_q[B_RIRR];
        if (sw_wr) begin
            if (!ent_d[B_TRIG]) ent_d[B_RIRR] = 1'b0;
        end else if (irr_set) begin
            ent_d[B_RIRR] = 1'b1;
        end else if (irr_clr) begin
            ent_d[B_RIRR] = 1'b0;
        end
        ent_d[B_DSTAT] = pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= ENT_RST;
        else        ent_q <= ent_d;
    end

    assign entry_o = ent_q;

    AST_RIRR_KEPT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> (!entry_o[B_TRIG] || entry_o[B_RIRR] == $past(entry_o[B_RIRR]))); // R7
    AST_EDGE_CLEARS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> (entry_o[B_TRIG] || !entry_o[B_RIRR])); // R8
    AST_HOOK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi && irr_set) |=> entry_o[B_RIRR]); // R9
    AST_HOOK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi && !irr_set && irr_clr) |=> !entry_o[B_RIRR]); // R9
    AST_DSTAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> entry_o[B_DSTAT] == $past(pend)); // R11
endmodule

// File: rtl/rw_readmux.sv
`timescale 1ns/1ps
module rw_readmux
    import redir_pkg::*;
#(
    parameter int NUM_PINS  = 24,
    parameter int ID_W      = 4,
    parameter int ID_LSB    = 24,
    parameter int TBL_BASE  = 16,
    parameter int IDX_ID    = 0,
    parameter int IDX_VER   = 1,
    parameter logic [7:0] VERSION = 8'h11,
    parameter logic [7:0] OFF_SEL = 8'h00,
    parameter logic [7:0] OFF_WIN = 8'h10
)(
    input  logic [7:0]               addr_lo,
    input  logic [IDX_W-1:0]         sel,
    input  logic [ID_W-1:0]          id,
    input  logic [NUM_PINS*ENT_W-1:0] entries,
    output logic [WORD_W-1:0]        rdata
);
    localparam logic [WORD_W-1:0] VER_WORD = {8'h00, 8'(NUM_PINS-1), 8'h00, VERSION};

    logic [WORD_W-1:0] win_word;
    logic              in_rng;
    int                ent_idx;

    always_comb begin
        in_rng  = (int'(sel) >= TBL_BASE) && ((int'(sel) - TBL_BASE) < 2*NUM_PINS);
        ent_idx = (int'(sel) - TBL_BASE) >>> 1;
        win_word = '0;
        if (int'(sel) == IDX_ID) begin
            win_word = WORD_W'(id) << ID_LSB;
        end else if (int'(sel) == IDX_VER) begin
            win_word = VER_WORD;
        end else if (in_rng) begin
            for (int k = 0; k < NUM_PINS; k++) begin
                if (ent_idx == k) begin
                    win_word = sel[0] ? entries[k*ENT_W+WORD_W +: WORD_W]
                                      : entries[k*ENT_W +: WORD_W];
                end
            end
        end
        if (addr_lo == OFF_SEL)      rdata = {{(WORD_W-IDX_W){1'b0}}, sel};
        else if (addr_lo == OFF_WIN) rdata = win_word;
        else                         rdata = '0;
    end
endmodule

// File: rtl/redir_regwin.sv
`timescale 1ns/1ps
module redir_regwin
    import redir_pkg::*;
#(
    parameter int NUM_PINS  = 24,
    parameter int ADDR_W    = 12,
    parameter int ID_W      = 4,
    parameter int ID_LSB    = 24,
    parameter int TBL_BASE  = 16,
    parameter logic [7:0] VERSION = 8'h11
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_PINS-1:0]       irr_set,
    input  logic [NUM_PINS-1:0]       irr_clr,
    input  logic [NUM_PINS-1:0]       pend_i,
    output logic [NUM_PINS*64-1:0]    entries_o
);
    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam int         IDX_ID  = 0;
    localparam int         IDX_VER = 1;

    typedef struct packed {
        logic [IDX_W-1:0] sel;
        logic [ID_W-1:0]  id;
    } regs_t;

    regs_t               r_d, r_q;
    logic [7:0]          addr_lo;
    logic                sel_wr, win_wr, in_rng;
    int                  ent_idx;
    logic [NUM_PINS-1:0] wr_lo, wr_hi;
    logic                unused_addr_hi;

    assign addr_lo        = bus_addr[7:0];
    assign unused_addr_hi = ^bus_addr;

    always_comb begin
        sel_wr  = bus_valid && bus_write && (addr_lo == OFF_SEL);
        win_wr  = bus_valid && bus_write && (addr_lo == OFF_WIN);
        in_rng  = (int'(r_q.sel) >= TBL_BASE) && ((int'(r_q.sel) - TBL_BASE) < 2*NUM_PINS);
        ent_idx = (int'(r_q.sel) - TBL_BASE) >>> 1;
        r_d = r_q;
        if (sel_wr) r_d.sel = bus_wdata[IDX_W-1:0];
        if (win_wr && int'(r_q.sel) == IDX_ID) r_d.id = bus_wdata[ID_LSB +: ID_W];
        for (int k = 0; k < NUM_PINS; k++) begin
            wr_lo[k] = win_wr && in_rng && (ent_idx == k) && !r_q.sel[0];
            wr_hi[k] = win_wr && in_rng && (ent_idx == k) &&  r_q.sel[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        rw_entry u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (wr_lo[g]),
            .wr_hi   (wr_hi[g]),
            .wdata   (bus_wdata),
            .irr_set (irr_set[g]),
            .irr_clr (irr_clr[g]),
            .pend    (pend_i[g]),
            .entry_o (entries_o[g*64 +: 64])
        );
    end

    rw_readmux #(
        .NUM_PINS (NUM_PINS),
        .ID_W     (ID_W),
        .ID_LSB   (ID_LSB),
        .TBL_BASE (TBL_BASE),
        .IDX_ID   (IDX_ID),
        .IDX_VER  (IDX_VER),
        .VERSION  (VERSION),
        .OFF_SEL  (OFF_SEL),
        .OFF_WIN  (OFF_WIN)
    ) u_rd (
        .addr_lo (addr_lo),
        .sel     (r_q.sel),
        .id      (r_q.id),
        .entries (entries_o),
        .rdata   (bus_rdata)
    );

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && addr_lo == OFF_SEL) |=> $stable(r_q.sel)); // R2
    AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && addr_lo == OFF_WIN && r_q.sel == 8'(IDX_ID)) |=> $stable(r_q.id)); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_lo != OFF_SEL && addr_lo != OFF_WIN) |-> bus_rdata == 32'h0); // R12
    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_lo == OFF_WIN && !in_rng && int'(r_q.sel) != IDX_ID && int'(r_q.sel) != IDX_VER)
        |-> bus_rdata == 32'h0); // R6
    AST_OOR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_rng |-> $countones({wr_lo, wr_hi}) == 0); // R6
endmodule

// File: tb/tb_redir_regwin.sv
`timescale 1ns/1ps
module tb_redir_regwin;
    localparam int NP = 4;
    localparam int AW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   irr_set = '0, irr_clr = '0, pend_i = '0;
    logic [NP*64-1:0] entries_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    redir_regwin #(.NUM_PINS(NP), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irr_set(irr_set), .irr_clr(irr_clr), .pend_i(pend_i), .entries_o(entries_o)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h000, 32'h0000_0000, 4'd3},  // R3 select ID
        '{1'b0, 12'h010, 32'h0000_0000, 4'd1},  // R1 ID after reset
        '{1'b1, 12'h010, 32'hFFFF_FFFF, 4'd3},
        '{1'b0, 12'h010, 32'h0F00_0000, 4'd3},  // R3 field 27:24 only
        '{1'b1, 12'h000, 32'h0000_0001, 4'd4},
        '{1'b0, 12'h010, 32'h0003_0011, 4'd4},  // R4 version word
        '{1'b1, 12'h010, 32'hFFFF_FFFF, 4'd4},
        '{1'b0, 12'h010, 32'h0003_0011, 4'd4},  // R4 write ignored
        '{1'b0, 12'h000, 32'h0000_0001, 4'd2},  // R2 select readback
        '{1'b1, 12'h000, 32'h0000_0012, 4'd5},
        '{1'b0, 12'h010, 32'h0001_0000, 4'd1},  // R1 entry reset value
        '{1'b1, 12'h010, 32'h0000_D031, 4'd7},
        '{1'b0, 12'h010, 32'h0000_8031, 4'd7},  // R7 RO bits kept
        '{1'b1, 12'h000, 32'h0000_0013, 4'd5},
        '{1'b1, 12'h010, 32'hAB00_0000, 4'd5},
        '{1'b0, 12'h010, 32'hAB00_0000, 4'd5},  // R5 high half
        '{1'b1, 12'h000, 32'h0000_0018, 4'd6},
        '{1'b0, 12'h010, 32'h0000_0000, 4'd6},  // R6 past table end
        '{1'b1, 12'h010, 32'hFFFF_FFFF, 4'd6},
        '{1'b0, 12'h010, 32'h0000_0000, 4'd6},
        '{1'b1, 12'h000, 32'h0000_0005, 4'd6},
        '{1'b0, 12'h010, 32'h0000_0000, 4'd6},  // R6 gap index
        '{1'b0, 12'h004, 32'h0000_0000, 4'd12}, // R12 unmapped read
        '{1'b1, 12'h004, 32'h0000_00FF, 4'd12},
        '{1'b0, 12'h000, 32'h0000_0005, 4'd12}, // R12 write ignored
        '{1'b1, 12'h100, 32'h0000_0012, 4'd2},
        '{1'b0, 12'h000, 32'h0000_0012, 4'd2},  // R2 bit 8 ignored
        '{1'b0, 12'h110, 32'h0000_8031, 4'd5}   // R5 window alias
    };

    task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d,
                      input logic [NP-1:0] s, input logic [NP-1:0] c);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        irr_set = s; irr_clr = c;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; irr_set = '0; irr_clr = '0;
    endtask

    task automatic hook(input logic [NP-1:0] s, input logic [NP-1:0] c);
        @(negedge clk);
        irr_set = s; irr_clr = c;
        @(negedge clk);
        irr_set = '0; irr_clr = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input int req);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #2;
        chk(req, {32'h0, bus_rdata}, {32'h0, exp});
        bus_valid = 1'b0;
    endtask

    task automatic rd_win(input logic [7:0] idx, input logic [31:0] exp, input int req);
        wr(12'h000, {24'h0, idx}, '0, '0);
        rd(12'h010, exp, req);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state of entries and select
        for (int k = 0; k < NP; k++) chk(1, entries_o[k*64 +: 64], 64'h0000_0000_0001_0000);
        rd(12'h000, 32'h0, 1);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data, '0, '0);
            else            rd(VECS[i].addr, VECS[i].data, int'(VECS[i].req));
        end

        // R6 out-of-range writes left other entries and ID untouched
        chk(6, entries_o[0 +: 64],   64'h0000_0000_0001_0000);
        chk(6, entries_o[128 +: 64], 64'h0000_0000_0001_0000);
        chk(6, entries_o[192 +: 64], 64'h0000_0000_0001_0000);
        rd_win(8'h00, 32'h0F00_0000, 6);
        // R5 entry exported on entries_o
        chk(5, entries_o[64 +: 64], 64'hAB00_0000_0000_8031);

        // R9 hooks on entry 1 (level mode)
        hook(4'b0010, 4'b0000);
        rd_win(8'h12, 32'h0000_C031, 9);
        wr(12'h010, 32'h0000_8031, '0, '0);
        rd(12'h010, 32'h0000_C031, 7);            // R7 remote IRR kept
        hook(4'b0000, 4'b0010);
        rd(12'h010, 32'h0000_8031, 9);
        hook(4'b0010, 4'b0010);
        rd(12'h010, 32'h0000_C031, 9);            // R9 set wins

        // R8 edge-mode write clears remote IRR
        wr(12'h000, 32'h13, '0, '0);
        wr(12'h010, 32'hAB00_0000, '0, '0);
        rd_win(8'h12, 32'h0000_C031, 8);          // level: stays
        wr(12'h010, 32'h0000_0031, '0, '0);
        rd(12'h010, 32'h0000_0031, 8);
        hook(4'b0010, 4'b0000);
        rd(12'h010, 32'h0000_4031, 9);
        wr(12'h000, 32'h13, '0, '0);
        wr(12'h010, 32'hAB00_0000, '0, '0);
        rd_win(8'h12, 32'h0000_0031, 8);          // high-half write clears too

        // R10 collisions between hooks and software writes
        wr(12'h010, 32'h0000_8031, '0, '0);
        wr(12'h010, 32'h0000_8032, 4'b0010, '0);
        rd(12'h010, 32'h0000_8032, 10);
        hook(4'b0010, 4'b0000);
        wr(12'h010, 32'h0000_8033, '0, 4'b0010);
        rd(12'h010, 32'h0000_C033, 10);
        wr(12'h010, 32'h0000_0033, 4'b0011, '0);
        rd(12'h010, 32'h0000_0033, 10);
        rd_win(8'h10, 32'h0001_4000, 9);          // R9 neighbour hook still applied
        chk(10, entries_o[64 +: 64], 64'hAB00_0000_0000_0033);

        // R11 delivery status follows pend_i
        @(negedge clk); pend_i = 4'b0100;
        rd_win(8'h14, 32'h0001_1000, 11);
        wr(12'h010, 32'h0000_0000, '0, '0);
        rd(12'h010, 32'h0000_1000, 7);            // R7 delivery status kept
        @(negedge clk); pend_i = 4'b0000;
        rd(12'h010, 32'h0000_0000, 11);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule